// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Model

This block models the slave side of a 256-byte two-wire serial EEPROM. Software on a host toggles clock and data levels through registers. Each new pair of levels reaches the block as one sample, marked by a one-cycle `smp_en` strobe. The block compares every sample with the one before it. From that it finds start and stop conditions and counts rising edges of the serial clock.

A transaction opens with a start condition, followed by an eight-bit command. The command's least significant bit selects the direction: 1 is read, 0 is write. After the eighth command bit the block pulls its data output low as an acknowledge. In a write transaction the next eight bits form a byte address. On the seventeenth clock the data register is loaded from storage at that address. In a later read transaction the block shifts that byte out, MSB first, on its data output.

The stored contents come from a parameter array that is fixed at build time. They are never changed by the serial protocol. The host must release the data line during read bits; the model does not resolve the wired line itself.

Top module: `eeprom_wire_slave`

## Requirements
- R1: After reset, `sda_out` is 1, `read_mode` is 0 and `proto_err` is 0.
- R2: Both clock samples high with a data change is a bus event. A data fall is a start: it clears the clock counter, arms the block, clears `proto_err` and clears `read_mode`. A data rise is a stop: it clears the counter and disarms the block. `sda_out` returns to 1 on either event.
- R3: While the counter is zero and the block is not armed, clock edges are ignored, so no acknowledge appears after eight clocks.
- R4: A bit is taken only on a clock rise (previous sample low, current sample high) whose data level equals the previous sample's data level.
- R5: Clocks 1 to 8 shift data MSB first into an 8-bit command. After the 8th rise `sda_out` is 0 (acknowledge). After the 9th rise `read_mode` equals command bit 0.
- R6: In write mode, clocks 10 to 17 shift an 8-bit address in MSB first. On clock 17 the data register is loaded from storage at that address, and `sda_out` is 1 from the 9th rise on.
- R7: In read mode, after rises 9 to 16 `sda_out` carries data register bits 7 down to 0. After rise 17 `sda_out` is 1 and the data register is reloaded from the current address.
- R8: A clock rise with a changed data level sets `proto_err` and takes no bit. `proto_err` stays set until the next start.
- R9: The counter stops at 17. Further clocks leave `sda_out` at 1 until the next start.
- R10: Storage contents come from the `PRELOAD` parameter. Without `smp_en` no output or counter state changes, whatever the line inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_en | input | 1 | One-cycle strobe marking a new line sample |
| scl_in | input | 1 | Sampled serial clock level |
| sda_in | input | 1 | Sampled serial data level from the host |
| sda_out | output | 1 | Data level driven by the slave (1 = released) |
| read_mode | output | 1 | Direction taken from the command, valid from clock 9 |
| proto_err | output | 1 | Sticky flag for a data change on a clock rise |

## Verification
The bench builds the block with the default 8-bit width and overrides `PRELOAD` with distinct values at address 0, 5 and 255. All other addresses hold a common default value. This lets a read-back check both ends of the address range and an unlisted entry, and a wrong byte or a bit-order slip shows up as a value mismatch. The same build covers the full 17-clock sequence, so the acknowledge slot, the direction decode and the saturation after the last clock all fall inside short directed transactions.

// File: rtl/eeprom_wire_slave.sv
module eeprom_wire_slave #(
  parameter int W = 8,
  parameter int DEPTH = 1 << W,
  parameter logic [W-1:0] PRELOAD [DEPTH] = '{default: '0}
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_out,
  output logic read_mode,
  output logic proto_err
);
  localparam int LAST = 2 * W + 1;
  localparam int CW = $clog2(LAST + 1);
  localparam logic [CW-1:0] C_ACK = CW'(W);
  localparam logic [CW-1:0] C_DIR = CW'(W + 1);
  localparam logic [CW-1:0] C_END = CW'(LAST);

  logic          scl_q, sda_q, active;
  logic [CW-1:0] tick;
  logic [W-1:0]  cmd, addr, data;

  wire           rise    = !scl_q && scl_in;
  wire           same    = (sda_q == sda_in);
  wire           bus_ev  = scl_q && scl_in && !same;
  wire           idle    = (tick == '0) && !active;
  wire [CW-1:0]  nxt     = tick + 1'b1;
  wire [W-1:0]   addr_nx = {addr[W-2:0], sda_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      active    <= 1'b0;
      tick      <= '0;
      cmd       <= '0;
      addr      <= '0;
      data      <= '0;
      sda_out   <= 1'b1;
      read_mode <= 1'b0;
      proto_err <= 1'b0;
    end else if (smp_en) begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (bus_ev) begin
        tick    <= '0;
        active  <= !sda_in;
        sda_out <= 1'b1;
        if (!sda_in) begin
          proto_err <= 1'b0;
          read_mode <= 1'b0;
        end
      end else if (!idle && rise) begin
        if (!same) begin
          proto_err <= 1'b1;
        end else if (tick != C_END) begin
          tick <= nxt;
          if (nxt <= C_ACK) cmd <= {cmd[W-2:0], sda_in};
          if (nxt == C_ACK) sda_out <= 1'b0;
          if (nxt == C_DIR) begin
            read_mode <= cmd[0];
            if (cmd[0]) begin
              sda_out <= data[W-1];
              data    <= {data[W-2:0], 1'b0};
            end else begin
              sda_out <= 1'b1;
            end
          end
          if (nxt > C_DIR) begin
            if (!read_mode) addr <= addr_nx;
            if (read_mode && nxt != C_END) begin
              sda_out <= data[W-1];
              data    <= {data[W-2:0], 1'b0};
            end else begin
              sda_out <= 1'b1;
            end
          end
          if (nxt == C_END) data <= PRELOAD[read_mode ? addr : addr_nx];
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_wire_slave_chk.sv
module eeprom_wire_slave_chk #(
  parameter int W = 8
) (
  input logic clk,
  input logic rst_n,
  input logic smp_en,
  input logic scl_in,
  input logic sda_in,
  input logic scl_q,
  input logic sda_q,
  input logic sda_out,
  input logic proto_err,
  input logic [$clog2(2*W+2)-1:0] tick
);
  localparam int CW = $clog2(2 * W + 2);
  localparam logic [CW-1:0] C_ACK = CW'(W);
  localparam logic [CW-1:0] C_END = CW'(2 * W + 1);

  // R9
  tick_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick <= C_END);

  // R4
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick != $past(tick)) |-> (tick == '0 || tick == CW'($past(tick) + 1'b1)));

  // R5
  ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick == C_ACK) |-> !sda_out);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> ($stable(sda_out) && $stable(proto_err) && $stable(tick)));

  // R8
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proto_err) |-> $past(smp_en && scl_in && !scl_q));

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && scl_q && scl_in && sda_q && !sda_in) |=> (tick == '0 && !proto_err && sda_out));
endmodule

bind eeprom_wire_slave eeprom_wire_slave_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .scl_in(scl_in), .sda_in(sda_in),
  .scl_q(scl_q), .sda_q(sda_q), .sda_out(sda_out), .proto_err(proto_err), .tick(tick)
);

// File: tb/sim_eeprom_wire_slave.sv
module sim_eeprom_wire_slave;
  localparam logic [7:0] IMG [256] = '{0: 8'h3C, 5: 8'h81, 255: 8'hF0, default: 8'h5A};

  logic clk = 1'b0, rst_n = 1'b0, smp_en = 1'b0, scl_in = 1'b1, sda_in = 1'b1;
  logic sda_out, read_mode, proto_err;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  eeprom_wire_slave #(.W(8), .PRELOAD(IMG)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .scl_in(scl_in), .sda_in(sda_in),
    .sda_out(sda_out), .read_mode(read_mode), .proto_err(proto_err)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic smp(input logic s, input logic d);
    @(negedge clk);
    scl_in = s; sda_in = d; smp_en = 1'b1;
    @(negedge clk);
    smp_en = 1'b0;
  endtask

  task automatic put_bit(input logic b, output logic got);
    smp(1'b0, b);
    smp(1'b1, b);
    got = sda_out;
    smp(1'b0, b);
  endtask

  task automatic do_start();
    smp(1'b0, 1'b1); smp(1'b1, 1'b1); smp(1'b1, 1'b0); smp(1'b0, 1'b0);
  endtask

  task automatic do_stop();
    smp(1'b0, 1'b0); smp(1'b1, 1'b0); smp(1'b1, 1'b1);
  endtask

  task automatic send_cmd(input logic [7:0] c, input string tag);
    logic g;
    for (int i = 7; i >= 0; i--) put_bit(c[i], g);
    chk({7'd0, g}, 8'd0, {tag, " R5 ack after 8th clock"});
  endtask

  task automatic txn_write(input logic [7:0] a);
    logic g;
    do_start();
    send_cmd(8'hA0, "write");
    put_bit(1'b1, g);
    chk({7'd0, read_mode}, 8'd0, "R5 read_mode after write command");
    chk({7'd0, g}, 8'd1, "R6 line released in write mode");
    for (int i = 7; i >= 0; i--) put_bit(a[i], g);
    chk({7'd0, g}, 8'd1, "R6 line released after address");
  endtask

  task automatic txn_read(input logic [7:0] exp, input string tag);
    logic [7:0] got;
    logic g;
    do_start();
    send_cmd(8'hA1, "read");
    for (int i = 7; i >= 0; i--) begin
      put_bit(1'b1, g);
      got[i] = g;
      if (i == 7) chk({7'd0, read_mode}, 8'd1, "R5 read_mode after read command");
    end
    chk(got, exp, {"R7 R10 read data ", tag});
    put_bit(1'b1, g);
    chk({7'd0, g}, 8'd1, "R7 released after clock 17");
  endtask

  task automatic t_reset();
    chk({7'd0, sda_out}, 8'd1, "R1 sda_out");
    chk({7'd0, read_mode}, 8'd0, "R1 read_mode");
    chk({7'd0, proto_err}, 8'd0, "R1 proto_err");
  endtask

  task automatic t_idle();
    logic g;
    for (int i = 0; i < 8; i++) put_bit(1'b0, g);
    chk({7'd0, g}, 8'd1, "R3 no ack without start");
  endtask

  task automatic t_rw();
    txn_write(8'd5);   txn_read(8'h81, "addr 5");
    txn_write(8'd0);   txn_read(8'h3C, "addr 0");
    txn_write(8'd255); txn_read(8'hF0, "addr 255");
    txn_write(8'h77);  txn_read(8'h5A, "addr 0x77");
  endtask

  task automatic t_violation();
    logic g;
    do_start();
    put_bit(1'b1, g); put_bit(1'b0, g); put_bit(1'b1, g);
    smp(1'b0, 1'b0);
    smp(1'b1, 1'b1);
    chk({7'd0, proto_err}, 8'd1, "R8 error on data change at rise");
    smp(1'b0, 1'b1);
    for (int i = 0; i < 4; i++) put_bit(1'b0, g);
    chk({7'd0, g}, 8'd1, "R8 R4 violating clock not counted");
    put_bit(1'b0, g);
    chk({7'd0, g}, 8'd0, "R4 ack after 8 accepted bits");
    chk({7'd0, proto_err}, 8'd1, "R8 error is sticky");
    do_start();
    chk({7'd0, proto_err}, 8'd0, "R2 start clears error");
  endtask

  task automatic t_restart();
    logic g;
    do_start();
    put_bit(1'b1, g); put_bit(1'b0, g); put_bit(1'b1, g);
    do_stop();
    for (int i = 0; i < 8; i++) put_bit(1'b1, g);
    chk({7'd0, g}, 8'd1, "R2 stop disarms block");
    do_start();
    put_bit(1'b1, g); put_bit(1'b1, g); put_bit(1'b1, g);
    do_start();
    send_cmd(8'hA0, "R2 repeated start");
    chk({7'd0, sda_out}, 8'd0, "R10 ack held");
    @(negedge clk); scl_in = 1'b1; sda_in = 1'b1;
    @(negedge clk); sda_in = 1'b0;
    @(negedge clk); scl_in = 1'b0; sda_in = 1'b1;
    @(negedge clk);
    chk({7'd0, sda_out}, 8'd0, "R10 no change without smp_en");
    chk({7'd0, proto_err}, 8'd0, "R10 error unchanged without smp_en");
    do_stop();
    chk({7'd0, sda_out}, 8'd1, "R2 stop releases line");
  endtask

  task automatic t_saturate();
    logic g;
    logic any_low;
    txn_write(8'd5);
    any_low = 1'b0;
    for (int i = 0; i < 12; i++) begin
      put_bit(1'b0, g);
      if (!g) any_low = 1'b1;
    end
    chk({7'd0, any_low}, 8'd0, "R9 no ack after clock 17");
    txn_read(8'h81, "after saturation");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_rw();
    t_violation();
    t_restart();
    t_saturate();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule